// File: doc/BRIEF.md
# Banked Operand Register File with Bank-Conflict Serialization

This block is the main register file of a four-lane SIMT cluster. It stores each architectural register of each warp as one 128-bit row. The row holds a 32-bit slot for every lane. The rows are spread over four banks, and each bank allows one read and one write per cycle. Bits [1:0] of the register number pick the bank. The warp number and the upper register bits pick the row inside that bank. Spreading consecutive register numbers over different banks lets most instructions fetch all their sources in a single cycle.

An instruction presents a warp number, up to three source register numbers and one enable bit per source. The block reads its operands in the same cycle it accepts the instruction. A bank can only deliver one row per cycle, so when several distinct source registers map to the same bank, the extra reads are spread over later cycles. While that happens the request side is stalled. Fetched rows gather in an operand buffer. Once the last one is in, all operands are presented together with a one-cycle valid pulse. A single writeback port writes one register per cycle. It does not forward to a read in the same cycle.

Top module: `opnd_regfile`

## Requirements
- R1: In the first cycle after reset is released, `req_ready` is 1, `opnd_valid` is 0 and every bit of `opnd_data` is 0.
- R2: A register written through the writeback port with warp `w` and number `r` is returned unchanged by a later read of the same warp and number. Reads with a different warp or number do not return it. The bank is `r mod 4` and the row in that bank is `w*(REGS_PER_WARP/4) + r/4`.
- R3: If all enabled sources of an accepted instruction are in different banks, `opnd_valid` is 1 in the cycle after acceptance. `req_ready` stays 1, so a new instruction can be accepted every cycle.
- R4: Among the enabled, distinct source registers that share one bank, each one after the first adds one cycle. `opnd_valid` rises N cycles after acceptance, where N is the largest count of distinct registers in any single bank (1 to 3).
- R5: After an instruction that needs N > 1 cycles is accepted, `req_ready` is 0 for the next N-1 cycles. A request offered in that window is not accepted and is taken only once `req_ready` returns to 1.
- R6: Source fields that name the same register are read once, add no cycle, and each receives that register's value.
- R7: A source whose enable bit is 0 does not count toward bank conflicts, and its operand field of `opnd_data` (bits [128*i+127:128*i] for source i) is 0. An instruction with no enabled source is valid one cycle after acceptance with all-zero data.
- R8: A bank read and a write to the same register in the same cycle are both carried out. The read returns the value from before the write. A source read in a later cycle of the same instruction sees the new value.
- R9: Each accepted instruction produces exactly one `opnd_valid` pulse, one cycle wide, in acceptance order. `opnd_valid` is never 1 while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Instruction operand request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_warp | input | WARP_W | Warp number of the request |
| req_reg | input | NUM_SRC*REG_W | Source register numbers, source i in bits [REG_W*i +: REG_W] |
| req_use | input | NUM_SRC | Per-source enable |
| wb_en | input | 1 | Writeback enable |
| wb_warp | input | WARP_W | Writeback warp number |
| wb_reg | input | REG_W | Writeback register number |
| wb_data | input | LANES*LANE_W | Writeback row, lane k in bits [32*k +: 32] |
| opnd_valid | output | 1 | Gathered operands present this cycle |
| opnd_data | output | NUM_SRC*LANES*LANE_W | Gathered operand rows, source i in bits [128*i +: 128] |

## Verification
The bench builds the block with WARPS=4 and REGS_PER_WARP=16, so each bank has 16 rows. The whole file can be filled with distinct values in 64 writebacks, which means any wrong bank or row mapping, including a wrong warp offset, shows up as aliased data. Register numbers up to 15 allow three distinct registers in every bank. The tests cover two-way and three-way conflicts, duplicate and disabled sources, requests held during a stall, and writes that hit a register in the same cycle it is read or before a later conflict read.

// File: rtl/opnd_rf_pkg.sv
// Shared defaults for the banked operand register file.
// Assumes lane width and lane count describe one bank row.
package opnd_rf_pkg;
    localparam int LANE_BITS_DEF = 32;
    localparam int LANES_DEF     = 4;
    localparam int BANKS_DEF     = 4;
    localparam int SRCS_DEF      = 3;
endpackage

// File: rtl/opnd_rf_bank.sv
// One register bank: ROWS rows of ROW_W bits, one read and one write per cycle.
// The read is combinational from the array, so a same-cycle write is seen only
// by reads in later cycles (old value returned, no forwarding).
// Assumes ROWS is a power of two matching AW address bits.
module opnd_rf_bank #(
    parameter int ROWS  = 128,
    parameter int ROW_W = 128,
    parameter int AW    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [ROW_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [ROW_W-1:0] rdata
);
    logic [ROW_W-1:0] mem [ROWS];

    // read port: current contents at raddr
    assign rdata = mem[raddr];

    // write port: update one row at the clock edge
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/opnd_rf_sched.sv
// Conflict scheduler: gives each enabled source the cycle (slot) in which its
// bank reads it, and the number of cycles the whole instruction needs.
// A repeated register takes the slot of its first occurrence; a disabled
// source gets slot 0 and takes no bank time.
// Assumes the bank index is the low BANK_W bits of the register number.
module opnd_rf_sched #(
    parameter int NUM_SRC = 3,
    parameter int REG_W   = 6,
    parameter int BANK_W  = 2,
    parameter int CNT_W   = 2
) (
    input  logic [NUM_SRC*REG_W-1:0] src_reg,
    input  logic [NUM_SRC-1:0]       src_use,
    output logic [NUM_SRC*CNT_W-1:0] src_slot,
    output logic [CNT_W-1:0]         cycles
);
    logic [NUM_SRC-1:0] first_occ;
    logic [CNT_W-1:0]   slot_v [NUM_SRC];

    // slot assignment: count earlier distinct registers in the same bank
    always_comb begin
        cycles = CNT_W'(1);
        for (int i = 0; i < NUM_SRC; i++) begin
            slot_v[i]    = '0;
            first_occ[i] = src_use[i];
            for (int j = 0; j < i; j++) begin
                if (src_use[i] && first_occ[j] &&
                    src_reg[j*REG_W +: REG_W] == src_reg[i*REG_W +: REG_W]) begin
                    first_occ[i] = 1'b0;
                    slot_v[i]    = slot_v[j];
                end
            end
            if (first_occ[i]) begin
                for (int j = 0; j < i; j++) begin
                    if (first_occ[j] &&
                        src_reg[j*REG_W +: BANK_W] == src_reg[i*REG_W +: BANK_W]) begin
                        slot_v[i] = slot_v[i] + CNT_W'(1);
                    end
                end
            end
            if (slot_v[i] + CNT_W'(1) > cycles) begin
                cycles = slot_v[i] + CNT_W'(1);
            end
        end
    end

    // flatten slots for the ports
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            src_slot[i*CNT_W +: CNT_W] = slot_v[i];
        end
    end
endmodule

// File: rtl/opnd_rf_collect.sv
// Operand buffer: one ROW_W register per source, loaded from its bank's read
// data in the cycle whose step equals the source's slot. Disabled sources are
// loaded with zero. Contents are meaningful when the controller flags valid.
module opnd_rf_collect #(
    parameter int NUM_SRC   = 3,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 128,
    parameter int BANK_W    = 2,
    parameter int CNT_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  logic [CNT_W-1:0]           step,
    input  logic [NUM_SRC*CNT_W-1:0]   src_slot,
    input  logic [NUM_SRC-1:0]         src_use,
    input  logic [NUM_SRC*BANK_W-1:0]  src_bank,
    input  logic [NUM_BANKS*ROW_W-1:0] bank_rdata,
    output logic [NUM_SRC*ROW_W-1:0]   opnd_data
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        logic [BANK_W-1:0] bsel;
        assign bsel = src_bank[i*BANK_W +: BANK_W];

        // capture this source's row in its scheduled cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                opnd_data[i*ROW_W +: ROW_W] <= '0;
            end else if (active && src_slot[i*CNT_W +: CNT_W] == step) begin
                opnd_data[i*ROW_W +: ROW_W] <= src_use[i]
                    ? bank_rdata[32'(bsel)*ROW_W +: ROW_W] : '0;
            end
        end
    end
endmodule

// File: rtl/opnd_regfile.sv
// Banked operand register file for a four-lane SIMT cluster.
// Register r of warp w lives in bank r mod NUM_BANKS, row
// w*(REGS_PER_WARP/NUM_BANKS) + r/NUM_BANKS. An accepted instruction reads
// its first slot in the acceptance cycle; each further slot takes one more
// cycle with req_ready low. opnd_valid pulses the cycle after the last read.
// Assumes WARPS, REGS_PER_WARP and NUM_BANKS are powers of two and
// REGS_PER_WARP is a multiple of NUM_BANKS.
module opnd_regfile
    import opnd_rf_pkg::*;
#(
    parameter int WARPS         = 8,
    parameter int REGS_PER_WARP = 64,
    parameter int NUM_SRC       = SRCS_DEF,
    parameter int LANES         = LANES_DEF,
    parameter int LANE_W        = LANE_BITS_DEF,
    parameter int NUM_BANKS     = BANKS_DEF,
    localparam int ROW_W        = LANES * LANE_W,
    localparam int WARP_W       = $clog2(WARPS),
    localparam int REG_W        = $clog2(REGS_PER_WARP),
    localparam int BANK_W       = $clog2(NUM_BANKS),
    localparam int ROWS_PER_WRP = REGS_PER_WARP / NUM_BANKS,
    localparam int ROWS         = WARPS * ROWS_PER_WRP,
    localparam int AW           = $clog2(ROWS),
    localparam int CNT_W        = $clog2(NUM_SRC + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [WARP_W-1:0]        req_warp,
    input  logic [NUM_SRC*REG_W-1:0] req_reg,
    input  logic [NUM_SRC-1:0]       req_use,
    input  logic                     wb_en,
    input  logic [WARP_W-1:0]        wb_warp,
    input  logic [REG_W-1:0]         wb_reg,
    input  logic [ROW_W-1:0]         wb_data,
    output logic                     opnd_valid,
    output logic [NUM_SRC*ROW_W-1:0] opnd_data
);
    // row address of a register inside its bank
    function automatic logic [AW-1:0] row_of(input logic [WARP_W-1:0] w,
                                             input logic [REG_W-1:0] r);
        return AW'(w) * AW'(ROWS_PER_WRP) + AW'(r >> BANK_W);
    endfunction

    logic                     busy_q;
    logic [CNT_W-1:0]         step_q;
    logic [WARP_W-1:0]        held_warp;
    logic [NUM_SRC*REG_W-1:0] held_reg;
    logic [NUM_SRC-1:0]       held_use;

    logic [WARP_W-1:0]        cur_warp;
    logic [NUM_SRC*REG_W-1:0] cur_reg;
    logic [NUM_SRC-1:0]       cur_use;
    logic [NUM_SRC*CNT_W-1:0] cur_slot;
    logic [NUM_SRC*BANK_W-1:0] cur_bank;
    logic [CNT_W-1:0]         cur_cycles;
    logic [CNT_W-1:0]         step_now;
    logic                     accept;
    logic                     active;
    logic                     last_step;
    logic [NUM_BANKS*ROW_W-1:0] bank_rdata;

    assign req_ready = !busy_q;
    assign accept    = req_valid && !busy_q;
    assign active    = accept || busy_q;

    // source set in service: live request on acceptance, held copy afterwards
    always_comb begin
        cur_warp = busy_q ? held_warp : req_warp;
        cur_reg  = busy_q ? held_reg  : req_reg;
        cur_use  = busy_q ? held_use  : req_use;
        step_now = busy_q ? step_q    : '0;
    end

    assign last_step = (step_now == cur_cycles - CNT_W'(1));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bank_of
        assign cur_bank[i*BANK_W +: BANK_W] = cur_reg[i*REG_W +: BANK_W];
    end

    opnd_rf_sched #(
        .NUM_SRC(NUM_SRC), .REG_W(REG_W), .BANK_W(BANK_W), .CNT_W(CNT_W)
    ) u_sched (
        .src_reg (cur_reg),
        .src_use (cur_use),
        .src_slot(cur_slot),
        .cycles  (cur_cycles)
    );

    // service sequencing: hold the request and advance the step while slots remain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            step_q     <= '0;
            opnd_valid <= 1'b0;
            held_warp  <= '0;
            held_reg   <= '0;
            held_use   <= '0;
        end else begin
            opnd_valid <= active && last_step;
            if (accept && !last_step) begin
                busy_q    <= 1'b1;
                step_q    <= CNT_W'(1);
                held_warp <= req_warp;
                held_reg  <= req_reg;
                held_use  <= req_use;
            end else if (busy_q) begin
                if (last_step) begin
                    busy_q <= 1'b0;
                end else begin
                    step_q <= step_q + CNT_W'(1);
                end
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [AW-1:0] raddr;
        logic          we;

        // read address: the source scheduled on this bank in this step
        always_comb begin
            raddr = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
                if (cur_use[i] && cur_bank[i*BANK_W +: BANK_W] == BANK_W'(b) &&
                    cur_slot[i*CNT_W +: CNT_W] == step_now) begin
                    raddr = row_of(cur_warp, cur_reg[i*REG_W +: REG_W]);
                end
            end
        end

        assign we = wb_en && (wb_reg[BANK_W-1:0] == BANK_W'(b));

        opnd_rf_bank #(.ROWS(ROWS), .ROW_W(ROW_W), .AW(AW)) u_bank (
            .clk  (clk),
            .we   (we),
            .waddr(row_of(wb_warp, wb_reg)),
            .wdata(wb_data),
            .raddr(raddr),
            .rdata(bank_rdata[b*ROW_W +: ROW_W])
        );
    end

    opnd_rf_collect #(
        .NUM_SRC(NUM_SRC), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W),
        .BANK_W(BANK_W), .CNT_W(CNT_W)
    ) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .step      (step_now),
        .src_slot  (cur_slot),
        .src_use   (cur_use),
        .src_bank  (cur_bank),
        .bank_rdata(bank_rdata),
        .opnd_data (opnd_data)
    );
endmodule

// File: rtl/opnd_regfile_chk.sv
// Protocol checker for opnd_regfile, attached by bind below.
// Observes the request handshake, the scheduler's cycle count and the
// operand outputs.
module opnd_regfile_chk #(
    parameter int NUM_SRC = 3,
    parameter int DATA_W  = 384,
    parameter int CNT_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [NUM_SRC-1:0] req_use,
    input logic [CNT_W-1:0]   live_cycles,
    input logic               opnd_valid,
    input logic [DATA_W-1:0]  opnd_data
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !opnd_valid));

    // R3
    single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && live_cycles == CNT_W'(1)) |=> opnd_valid);

    // R5
    stall_on_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && live_cycles > CNT_W'(1)) |=> !req_ready);

    // R9
    no_valid_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !opnd_valid);

    // R7
    idle_sources_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_use == '0) |=> (opnd_valid && opnd_data == '0));
endmodule

bind opnd_regfile opnd_regfile_chk #(
    .NUM_SRC(NUM_SRC), .DATA_W(NUM_SRC * ROW_W), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_use    (req_use),
    .live_cycles(cur_cycles),
    .opnd_valid (opnd_valid),
    .opnd_data  (opnd_data)
);

// File: tb/opnd_regfile_test.sv
`timescale 1ns/1ps
module opnd_regfile_test;
    localparam int WARPS = 4;
    localparam int REGS  = 16;
    localparam int NSRC  = 3;
    localparam int RW    = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_warp = '0;
    logic [NSRC*4-1:0] req_reg = '0;
    logic [NSRC-1:0]   req_use = '0;
    logic              wb_en = 1'b0;
    logic [1:0]        wb_warp = '0;
    logic [3:0]        wb_reg = '0;
    logic [RW-1:0]     wb_data = '0;
    logic              opnd_valid;
    logic [NSRC*RW-1:0] opnd_data;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string tag = "R1";
    bit    chk_on = 0;
    int    n_accept = 0;
    int    n_valid = 0;

    always #5 clk = ~clk;

    opnd_regfile #(.WARPS(WARPS), .REGS_PER_WARP(REGS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_warp(req_warp), .req_reg(req_reg), .req_use(req_use),
        .wb_en(wb_en), .wb_warp(wb_warp), .wb_reg(wb_reg), .wb_data(wb_data),
        .opnd_valid(opnd_valid), .opnd_data(opnd_data)
    );

    function automatic logic [RW-1:0] pat(int w, int r, int g);
        return {32'(w*1000 + r*10 + g + 1), 32'(w ^ 32'h55), 32'(r*7 + g*3),
                32'hC0DE0000 + 32'(w*16 + r)};
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [RW-1:0] mref [WARPS*REGS];
    logic [RW-1:0] mbuf [NSRC];
    bit   mbusy = 0, mvalid = 0, m_acc = 0;
    int   m_w, m_step, m_k;
    int   m_r [NSRC];
    int   m_sl [NSRC];
    bit   m_u [NSRC];

    always @(posedge clk) begin
        bit nv;
        bit first [NSRC];
        m_acc = 0;
        if (!rst_n) begin
            mbusy = 0; mvalid = 0; m_step = 0;
            for (int i = 0; i < NSRC; i++) mbuf[i] = '0;
        end else begin
            nv = 0;
            if (!mbusy && req_valid) begin
                m_acc = 1; n_accept++;
                m_w = int'(req_warp); m_k = 1; m_step = 0; mbusy = 1;
                for (int i = 0; i < NSRC; i++) begin
                    m_r[i] = int'(req_reg[i*4 +: 4]);
                    m_u[i] = req_use[i];
                end
                // a register's read cycle: distinct earlier registers in its bank
                for (int i = 0; i < NSRC; i++) begin
                    m_sl[i] = 0; first[i] = m_u[i];
                    if (m_u[i])
                        for (int j = 0; j < i; j++)
                            if (first[j] && m_r[j] == m_r[i]) begin
                                first[i] = 0; m_sl[i] = m_sl[j];
                            end
                    if (first[i])
                        for (int j = 0; j < i; j++)
                            if (first[j] && (m_r[j] % 4) == (m_r[i] % 4)) m_sl[i]++;
                    if (m_sl[i] + 1 > m_k) m_k = m_sl[i] + 1;
                end
            end
            if (mbusy) begin
                for (int i = 0; i < NSRC; i++)
                    if (m_sl[i] == m_step)
                        mbuf[i] = m_u[i] ? mref[m_w*REGS + m_r[i]] : '0;
                if (m_step == m_k - 1) begin nv = 1; mbusy = 0; end
                else m_step++;
            end
            if (wb_en) mref[int'(wb_warp)*REGS + int'(wb_reg)] = wb_data;
            mvalid = nv;
        end
    end

    task automatic check(string req, bit ok, logic [RW-1:0] act, logic [RW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (chk_on) begin
            check(tag, req_ready === !mbusy, RW'(req_ready), RW'(!mbusy));
            check(tag, opnd_valid === mvalid, RW'(opnd_valid), RW'(mvalid));
            for (int i = 0; i < NSRC; i++)
                check(tag, opnd_data[i*RW +: RW] === mbuf[i], opnd_data[i*RW +: RW], mbuf[i]);
            if (opnd_valid) n_valid++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // offer a request (optionally with a write in the first offered cycle) until taken
    task automatic drive_req(int w, int r0, int r1, int r2, logic [2:0] use_b,
                             bit wr = 0, int ww = 0, int wr_r = 0, int wg = 0);
        @(negedge clk);
        req_valid = 1; req_warp = 2'(w); req_use = use_b;
        req_reg = {4'(r2), 4'(r1), 4'(r0)};
        wb_en = wr; wb_warp = 2'(ww); wb_reg = 4'(wr_r); wb_data = pat(ww, wr_r, wg);
        do begin @(posedge clk); #1; end while (!m_acc);
    endtask

    // request, then measure cycles from acceptance to opnd_valid
    task automatic issue_wait(string req, int w, int r0, int r1, int r2,
                              logic [2:0] use_b, int exp_lat,
                              bit wr = 0, int ww = 0, int wr_r = 0, int wg = 0);
        int n;
        drive_req(w, r0, r1, r2, use_b, wr, ww, wr_r, wg);
        @(negedge clk);
        req_valid = 0; wb_en = 0;
        if (exp_lat > 1) check("R5", req_ready === 1'b0, RW'(req_ready), RW'(0));
        n = 1;
        while (!opnd_valid && n < 8) begin @(negedge clk); n++; end
        check(req, n == exp_lat, RW'(n), RW'(exp_lat));
    endtask

    task automatic write_reg(int w, int r, int g);
        @(negedge clk);
        wb_en = 1; wb_warp = 2'(w); wb_reg = 4'(r); wb_data = pat(w, r, g);
        @(negedge clk);
        wb_en = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 chk_on = 1;
        @(negedge clk) rst_n = 1;
        // R1: reset state seen by the per-cycle comparison
        @(negedge clk);
        check("R1", req_ready === 1'b1 && opnd_valid === 1'b0 && opnd_data === '0,
              RW'({req_ready, opnd_valid}), RW'(2'b10));

        // R2: fill every register of every warp with a distinct value
        tag = "R2";
        for (int w = 0; w < WARPS; w++)
            for (int r = 0; r < REGS; r++) begin
                @(negedge clk);
                wb_en = 1; wb_warp = 2'(w); wb_reg = 4'(r); wb_data = pat(w, r, 0);
            end
        @(negedge clk) wb_en = 0;
        issue_wait("R2", 0, 0, 1, 2, 3'b111, 1);
        check("R2", opnd_data[RW +: RW] === pat(0, 1, 0), opnd_data[RW +: RW], pat(0, 1, 0));
        issue_wait("R2", 3, 13, 14, 15, 3'b111, 1);
        check("R2", opnd_data[2*RW +: RW] === pat(3, 15, 0), opnd_data[2*RW +: RW], pat(3, 15, 0));
        issue_wait("R2", 2, 5, 10, 7, 3'b111, 1);

        // R3: conflict-free back-to-back requests
        tag = "R3";
        drive_req(1, 0, 1, 2, 3'b111);
        drive_req(2, 3, 4, 9, 3'b111);
        drive_req(3, 11, 12, 6, 3'b111);
        @(negedge clk) req_valid = 0;
        repeat (3) @(negedge clk);

        // R4: two- and three-way bank conflicts
        tag = "R4";
        issue_wait("R4", 0, 0, 4, 8, 3'b111, 3);
        check("R4", opnd_data[2*RW +: RW] === pat(0, 8, 0), opnd_data[2*RW +: RW], pat(0, 8, 0));
        issue_wait("R4", 1, 1, 5, 2, 3'b111, 2);
        issue_wait("R4", 2, 3, 7, 11, 3'b111, 3);
        issue_wait("R4", 3, 2, 6, 15, 3'b111, 2);

        // R5: requests held during a stall are taken only afterwards
        tag = "R5";
        drive_req(0, 1, 5, 9, 3'b111);
        drive_req(1, 0, 1, 2, 3'b111);
        drive_req(2, 4, 8, 12, 3'b111);
        drive_req(3, 3, 3, 7, 3'b111);
        @(negedge clk) req_valid = 0;
        repeat (5) @(negedge clk);

        // R6: duplicate registers
        tag = "R6";
        issue_wait("R6", 1, 4, 4, 4, 3'b111, 1);
        check("R6", opnd_data[2*RW +: RW] === pat(1, 4, 0), opnd_data[2*RW +: RW], pat(1, 4, 0));
        issue_wait("R6", 2, 4, 8, 4, 3'b111, 2);

        // R7: disabled sources
        tag = "R7";
        issue_wait("R7", 0, 0, 4, 8, 3'b010, 1);
        check("R7", opnd_data[0 +: RW] === '0, opnd_data[0 +: RW], '0);
        issue_wait("R7", 0, 0, 4, 8, 3'b000, 1);
        check("R7", opnd_data === '0, opnd_data[0 +: RW], '0);
        issue_wait("R7", 3, 1, 5, 9, 3'b101, 2);

        // R8: write and read in the same cycle, and before a later conflict read
        tag = "R8";
        issue_wait("R8", 1, 5, 6, 7, 3'b111, 1, 1, 1, 5, 7);
        check("R8", opnd_data[0 +: RW] === pat(1, 5, 0), opnd_data[0 +: RW], pat(1, 5, 0));
        issue_wait("R8", 1, 5, 6, 7, 3'b111, 1);
        check("R8", opnd_data[0 +: RW] === pat(1, 5, 7), opnd_data[0 +: RW], pat(1, 5, 7));
        issue_wait("R8", 2, 0, 4, 8, 3'b111, 3, 1, 2, 8, 9);
        check("R8", opnd_data[2*RW +: RW] === pat(2, 8, 9), opnd_data[2*RW +: RW], pat(2, 8, 9));
        write_reg(2, 12, 4);
        issue_wait("R8", 2, 12, 13, 14, 3'b111, 1);
        check("R8", opnd_data[0 +: RW] === pat(2, 12, 4), opnd_data[0 +: RW], pat(2, 12, 4));

        // R9: one valid pulse per accepted instruction
        tag = "R9";
        repeat (4) @(negedge clk);
        check("R9", n_valid == n_accept, RW'(n_valid), RW'(n_accept));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule